// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block collects interrupt requests from a parameterized set of sources (32 by default) and presents at most one of them to the CPU at a time. Every source carries an enable flag, a pending flag and an 8-bit urgency value. Of that value, only the three most significant bits are kept and compared. Pending flags are set by a rising edge on the source's level line, or by software through the register port. Pending flags are cleared by software or by the CPU acknowledging the source.

The CPU sees a registered request and the number of the winning source. Asserting acknowledge marks that source as running and pushes its level onto a nesting stack. Asserting return pops the stack. A run-time grouping value divides the three level bits into a preemption part and a sub-order part. A new request interrupts a running handler only when its preemption part is strictly more urgent than the one on top of the stack. A threshold register and a global gate suppress requests without touching the per-source enables.

Top module: `prio_nest_irq`

## Requirements
- R1: After reset, all pending and enable flags and all levels are 0, grouping reads 7, threshold reads 0, the gate is open, the stack is empty and irq_req is 0.
- R2: The register address is {region[2:0], source[4:0]}. Region 0 holds the level, region 1 the enable flag (bit 0), region 2 the pending flag, region 3 is the software trigger, and region 4 holds control words (source field 0 = grouping, 1 = threshold, 2 = gate). Read data appears on reg_rdata one cycle after the access. A level write keeps wdata[7:5], and the low five bits read back as 0.
- R3: Among eligible sources, the numerically smallest level is requested.
- R4: Among eligible sources with equal level, the lowest source number is requested.
- R5: Grouping g gives min(g,3) preemption bits, taken from the top of the level. Grouping values 3 to 7 behave identically. A candidate preempts a running handler only if its preemption part is strictly smaller than that of the stack top.
- R6: A candidate whose preemption part equals the stack top's is held back, even with a better sub-order. It is requested after the returns that uncover a less urgent top or empty the stack.
- R7: Writing gate bit 0 = 1 closes the gate and 0 opens it. While the gate is closed, irq_req stays 0 and the enable flags are unchanged. A gate write returns the prior closed state in reg_rdata bit 0.
- R8: With a nonzero threshold level T (wdata[7:5]), sources whose level is T or higher are never requested. A threshold level of 0 disables this masking.
- R9: A pending source with its enable at 0 is not requested. Its pending flag is kept, and it is requested once it is enabled.
- R10: Writing region 2 with bit 0 = 0 discards a pending request. A line that stays high does not set the flag again.
- R11: A region 3 write, or a region 2 write with bit 0 = 1, sets the pending flag exactly as a line edge would.
- R12: An acknowledge while irq_req is high clears that source's pending flag and drops irq_req on the next cycle. If the source's line is still high, the flag is set again.
- R13: A return pops one stack entry. With an empty stack, any eligible source is requested. The stack never holds more than 8 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | N_SRC | Level interrupt lines, one per source |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Write when 1, read when 0 |
| reg_addr | input | 3+log2(N_SRC) | Region and source number |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read or write-response data |
| irq_req | output | 1 | Request to the CPU |
| irq_id | output | log2(N_SRC) | Source number of the request |
| irq_ack | input | 1 | CPU takes the requested source |
| irq_ret | input | 1 | CPU leaves the current handler |

## Verification
A corrupted pending or enable flag appears at irq_req and irq_id two clock edges after the stimulus: one edge latches the flag and a second edge registers the request. A flag that is dropped or stuck is also visible through a region 1 or region 2 read one cycle later. A wrong stack entry stays hidden until a later candidate is compared against it, or until a return uncovers it. At that point it appears as a preemption that should not happen, or as a tail request that is missing. For this reason the sequences nest two handlers, change the grouping while they are active, and then unwind one return at a time.

// File: rtl/pnic_pkg.sv
package pnic_pkg;
  localparam int RG_W  = 3;
  localparam int GRP_W = 3;

  typedef enum logic [RG_W-1:0] {
    RG_LEVEL  = 3'd0,
    RG_ENABLE = 3'd1,
    RG_PEND   = 3'd2,
    RG_TRIG   = 3'd3,
    RG_CTRL   = 3'd4
  } region_e;

  localparam int CTRL_GROUP  = 0;
  localparam int CTRL_THRESH = 1;
  localparam int CTRL_GATE   = 2;
endpackage

// File: rtl/pnic_src_bank.sv
module pnic_src_bank #(
  parameter int N_SRC    = 32,
  parameter int LVL_BITS = 3,
  parameter int ID_W     = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_SRC-1:0]    lines,
  input  logic [ID_W-1:0]     wr_id,
  input  logic                lvl_we,
  input  logic [LVL_BITS-1:0] wr_lvl,
  input  logic                en_we,
  input  logic                wr_bit,
  input  logic                set_we,
  input  logic                clr_we,
  input  logic                ack_fire,
  input  logic [ID_W-1:0]     ack_id,
  output logic [N_SRC-1:0]    pend_o,
  output logic [N_SRC-1:0]    en_o,
  output logic [LVL_BITS-1:0] lvl_o [N_SRC]
);
  logic [N_SRC-1:0] line_q;

  always_ff @(posedge clk) begin
    if (rst) line_q <= '0;
    else     line_q <= lines;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic                pend_q, en_q, pend_nxt, hit;
    logic [LVL_BITS-1:0] lvl_q;

    assign hit = (wr_id == ID_W'(i));

    always_comb begin
      pend_nxt = pend_q;
      if (clr_we && hit) pend_nxt = 1'b0;
      if (ack_fire && ack_id == ID_W'(i)) pend_nxt = lines[i];
      if ((lines[i] && !line_q[i]) || (set_we && hit)) pend_nxt = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q <= 1'b0;
        en_q   <= 1'b0;
        lvl_q  <= '0;
      end else begin
        pend_q <= pend_nxt;
        if (en_we && hit)  en_q  <= wr_bit;
        if (lvl_we && hit) lvl_q <= wr_lvl;
      end
    end

    assign pend_o[i] = pend_q;
    assign en_o[i]   = en_q;
    assign lvl_o[i]  = lvl_q;
  end
endmodule

// File: rtl/pnic_arbiter.sv
module pnic_arbiter #(
  parameter int N_SRC    = 32,
  parameter int LVL_BITS = 3,
  parameter int ID_W     = 5
) (
  input  logic [N_SRC-1:0]    elig,
  input  logic [LVL_BITS-1:0] lvl [N_SRC],
  output logic                win_valid,
  output logic [ID_W-1:0]     win_id,
  output logic [LVL_BITS-1:0] win_lvl
);
  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    win_lvl   = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (!win_valid || lvl[i] < win_lvl)) begin
        win_valid = 1'b1;
        win_id    = ID_W'(i);
        win_lvl   = lvl[i];
      end
    end
  end
endmodule

// File: rtl/pnic_nest_stack.sv
module pnic_nest_stack #(
  parameter int LVL_BITS = 3,
  parameter int DEPTH    = 8,
  parameter int SP_W     = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                push,
  input  logic [LVL_BITS-1:0] push_lvl,
  input  logic                pop,
  output logic                empty,
  output logic [LVL_BITS-1:0] top_lvl
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LVL_BITS-1:0] mem [DEPTH];
  logic [SP_W-1:0]     cnt_q, cnt_after;
  logic                pop_ok;

  assign pop_ok    = pop && (cnt_q != '0);
  assign cnt_after = cnt_q - SP_W'(pop_ok);
  assign empty     = (cnt_q == '0);
  assign top_lvl   = mem[IDX_W'(cnt_q - SP_W'(1))];

  always_ff @(posedge clk) begin
    if (push) mem[IDX_W'(cnt_after)] <= push_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_after + SP_W'(push);
  end

  // R13: a push never finds the stack full
  assert_stack_room_R13: assert property (@(posedge clk) disable iff (rst)
    push |-> (cnt_q < SP_W'(DEPTH)));

  // R5: every nested entry is strictly more urgent than the one beneath it
  assert_nest_urgent_R5: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !empty) |-> (push_lvl < top_lvl));
endmodule

// File: rtl/prio_nest_irq.sv
module prio_nest_irq
  import pnic_pkg::*;
#(
  parameter int N_SRC    = 32,
  parameter int PRIO_W   = 8,
  parameter int LVL_BITS = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [N_SRC-1:0]                irq_lines,
  input  logic                            reg_en,
  input  logic                            reg_we,
  input  logic [RG_W+$clog2(N_SRC)-1:0]   reg_addr,
  input  logic [PRIO_W-1:0]               reg_wdata,
  output logic [PRIO_W-1:0]               reg_rdata,
  output logic                            irq_req,
  output logic [$clog2(N_SRC)-1:0]        irq_id,
  input  logic                            irq_ack,
  input  logic                            irq_ret
);
  localparam int ID_W   = $clog2(N_SRC);
  localparam int ADDR_W = RG_W + ID_W;
  localparam int DEPTH  = 1 << LVL_BITS;
  localparam int SP_W   = $clog2(DEPTH + 1);
  localparam int PAD_W  = PRIO_W - LVL_BITS;

  logic [RG_W-1:0]     rg;
  logic [ID_W-1:0]     rid;
  logic                wr, lvl_we, en_we, set_we, clr_we, gate_we;
  logic [LVL_BITS-1:0] wr_lvl;

  assign rg      = reg_addr[ADDR_W-1 -: RG_W];
  assign rid     = reg_addr[ID_W-1:0];
  assign wr      = reg_en && reg_we;
  assign wr_lvl  = reg_wdata[PRIO_W-1 -: LVL_BITS];
  assign lvl_we  = wr && (rg == RG_LEVEL);
  assign en_we   = wr && (rg == RG_ENABLE);
  assign set_we  = wr && ((rg == RG_PEND && reg_wdata[0]) || rg == RG_TRIG);
  assign clr_we  = wr && (rg == RG_PEND) && !reg_wdata[0];
  assign gate_we = wr && (rg == RG_CTRL) && (rid == ID_W'(CTRL_GATE));

  logic [GRP_W-1:0]    grp_q;
  logic [LVL_BITS-1:0] thr_q;
  logic                gate_closed_q;
  logic                req_q;
  logic [ID_W-1:0]     id_q;
  logic [LVL_BITS-1:0] req_lvl_q;
  logic [PRIO_W-1:0]   rdata_q;
  logic                ack_fire;

  assign ack_fire = irq_ack && req_q;

  logic [N_SRC-1:0]    pend_vec, en_vec, elig;
  logic [LVL_BITS-1:0] lvl_arr [N_SRC];

  pnic_src_bank #(.N_SRC(N_SRC), .LVL_BITS(LVL_BITS), .ID_W(ID_W)) u_bank (
    .clk(clk), .rst(rst), .lines(irq_lines), .wr_id(rid),
    .lvl_we(lvl_we), .wr_lvl(wr_lvl), .en_we(en_we), .wr_bit(reg_wdata[0]),
    .set_we(set_we), .clr_we(clr_we), .ack_fire(ack_fire), .ack_id(id_q),
    .pend_o(pend_vec), .en_o(en_vec), .lvl_o(lvl_arr)
  );

  always_comb begin
    for (int i = 0; i < N_SRC; i++)
      elig[i] = pend_vec[i] && en_vec[i] && (thr_q == '0 || lvl_arr[i] < thr_q);
  end

  logic                win_valid;
  logic [ID_W-1:0]     win_id;
  logic [LVL_BITS-1:0] win_lvl;

  pnic_arbiter #(.N_SRC(N_SRC), .LVL_BITS(LVL_BITS), .ID_W(ID_W)) u_arb (
    .elig(elig), .lvl(lvl_arr),
    .win_valid(win_valid), .win_id(win_id), .win_lvl(win_lvl)
  );

  logic                stk_empty;
  logic [LVL_BITS-1:0] stk_top;

  pnic_nest_stack #(.LVL_BITS(LVL_BITS), .DEPTH(DEPTH), .SP_W(SP_W)) u_stack (
    .clk(clk), .rst(rst), .push(ack_fire), .push_lvl(req_lvl_q),
    .pop(irq_ret), .empty(stk_empty), .top_lvl(stk_top)
  );

  // preemption part: the top pbits of the implemented level
  function automatic logic [LVL_BITS-1:0] preempt_of(input logic [LVL_BITS-1:0] l,
                                                     input int unsigned pb);
    return l >> (LVL_BITS - pb);
  endfunction

  int unsigned pbits;
  logic        may_preempt, want;

  assign pbits       = (32'(grp_q) >= LVL_BITS) ? LVL_BITS : 32'(grp_q);
  assign may_preempt = stk_empty || (preempt_of(win_lvl, pbits) < preempt_of(stk_top, pbits));
  assign want        = win_valid && may_preempt && !gate_closed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q     <= 1'b0;
      id_q      <= '0;
      req_lvl_q <= '0;
    end else begin
      req_q     <= want && !ack_fire && !irq_ret;
      id_q      <= win_id;
      req_lvl_q <= win_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_q         <= GRP_W'(7);
      thr_q         <= '0;
      gate_closed_q <= 1'b0;
    end else if (wr && rg == RG_CTRL) begin
      if (rid == ID_W'(CTRL_GROUP))  grp_q         <= reg_wdata[GRP_W-1:0];
      if (rid == ID_W'(CTRL_THRESH)) thr_q         <= wr_lvl;
      if (rid == ID_W'(CTRL_GATE))   gate_closed_q <= reg_wdata[0];
    end
  end

  logic [PRIO_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (rg)
      RG_LEVEL:  rd_mux = {lvl_arr[rid], {PAD_W{1'b0}}};
      RG_ENABLE: rd_mux = PRIO_W'(en_vec[rid]);
      RG_PEND:   rd_mux = PRIO_W'(pend_vec[rid]);
      RG_CTRL: begin
        if (rid == ID_W'(CTRL_GROUP))  rd_mux = PRIO_W'(grp_q);
        if (rid == ID_W'(CTRL_THRESH)) rd_mux = {thr_q, {PAD_W{1'b0}}};
        if (rid == ID_W'(CTRL_GATE))   rd_mux = PRIO_W'(gate_closed_q);
      end
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (reg_en)  rdata_q <= !reg_we ? rd_mux :
                                 gate_we ? PRIO_W'(gate_closed_q) : '0;
  end

  assign reg_rdata = rdata_q;
  assign irq_req   = req_q;
  assign irq_id    = id_q;

  // independent optimality check of the arbiter result
  logic better_exists;
  always_comb begin
    better_exists = 1'b0;
    for (int j = 0; j < N_SRC; j++)
      if (elig[j] && (lvl_arr[j] < win_lvl ||
                      (lvl_arr[j] == win_lvl && j < int'(win_id))))
        better_exists = 1'b1;
  end

  // R3, R4: nothing eligible beats the selected source
  assert_arb_order_R4: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (!better_exists && elig[win_id]));

  // R8: the candidate always passes the threshold
  assert_thresh_pass_R8: assert property (@(posedge clk) disable iff (rst)
    (win_valid && thr_q != '0) |-> (win_lvl < thr_q));

  // R7: a closed gate silences the request from the next cycle on
  assert_gate_silent_R7: assert property (@(posedge clk) disable iff (rst)
    gate_closed_q |=> !irq_req);
endmodule

// File: tb/prio_nest_irq_test.sv
`timescale 1ns/1ps
module prio_nest_irq_test;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] irq_lines = '0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [7:0]  reg_addr = '0, reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq_req;
  logic [4:0]  irq_id;
  logic        irq_ack = 1'b0, irq_ret = 1'b0;

  always #2 clk = ~clk;

  prio_nest_irq uut (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_id(irq_id), .irq_ack(irq_ack), .irq_ret(irq_ret)
  );

  typedef struct {
    int kind;   // 0: request/id, 1: rdata
    int rq;
    int exp_req;
    int exp_val;
  } item_t;

  item_t sb_q[$];
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      item_t it;
      wait (sb_q.size() != 0);
      it = sb_q.pop_front();
      n_checks++;
      if (it.kind == 0) begin
        if (int'(irq_req) != it.exp_req ||
            (it.exp_req == 1 && int'(irq_id) != it.exp_val)) begin
          n_fail++;
          $display("FAIL R%0d: req/id actual %0d/%0d expected %0d/%0d",
                   it.rq, irq_req, irq_id, it.exp_req, it.exp_val);
        end
      end else if (int'(reg_rdata) != it.exp_val) begin
        n_fail++;
        $display("FAIL R%0d: rdata actual 0x%02h expected 0x%02h",
                 it.rq, reg_rdata, it.exp_val);
      end
    end
  end

  task automatic push_req(input int rq, input int r, input int id);
    item_t it;
    it.kind = 0; it.rq = rq; it.exp_req = r; it.exp_val = id;
    sb_q.push_back(it);
  endtask

  task automatic push_data(input int rq, input int d);
    item_t it;
    it.kind = 1; it.rq = rq; it.exp_req = 0; it.exp_val = d;
    sb_q.push_back(it);
  endtask

  task automatic wr(input int rg, input int id, input int d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1;
    reg_addr = {3'(rg), 5'(id)}; reg_wdata = 8'(d);
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic wr_chk(input int rg, input int id, input int d, input int exp, input int rq);
    wr(rg, id, d);
    push_data(rq, exp);
  endtask

  task automatic rd_chk(input int rg, input int id, input int exp, input int rq);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = {3'(rg), 5'(id)};
    @(negedge clk);
    reg_en = 1'b0;
    push_data(rq, exp);
  endtask

  task automatic chk_req(input int rq, input int r, input int id);
    repeat (3) @(negedge clk);
    push_req(rq, r, id);
  endtask

  task automatic set_line(input int i, input logic v);
    @(negedge clk);
    irq_lines[i] = v;
  endtask

  task automatic do_ack(input int rq);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    push_req(rq, 0, 0);   // request drops right after the acknowledge
  endtask

  task automatic do_ret();
    @(negedge clk); irq_ret = 1'b1;
    @(negedge clk); irq_ret = 1'b0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      report();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    push_req(1, 0, 0);
    rd_chk(0, 5, 8'h00, 1);
    rd_chk(1, 5, 0, 1);
    rd_chk(2, 5, 0, 1);
    rd_chk(4, 0, 7, 1);
    rd_chk(4, 1, 0, 1);
    rd_chk(4, 2, 0, 1);

    // R2: only the top three level bits are stored
    wr(0, 3, 8'hFF);
    rd_chk(0, 3, 8'hE0, 2);

    // R9: pending but disabled is held, then taken once enabled
    set_line(3, 1'b1);
    chk_req(9, 0, 0);
    wr(1, 3, 1);
    chk_req(9, 1, 3);
    // R12: acknowledge with line still high re-pends without self-preemption
    do_ack(12);
    chk_req(12, 0, 0);
    rd_chk(2, 3, 1, 12);
    set_line(3, 1'b0);
    // R13: return uncovers the re-pended source
    do_ret();
    chk_req(13, 1, 3);
    do_ack(12);
    rd_chk(2, 3, 0, 12);
    do_ret();
    chk_req(13, 0, 0);

    // R3, R4, R11: ordering and software set/trigger
    wr(0, 4, 8'h40); wr(0, 9, 8'h5F); wr(0, 6, 8'h20);
    wr(1, 4, 1); wr(1, 9, 1); wr(1, 6, 1);
    wr(2, 9, 1); wr(2, 4, 1);
    chk_req(4, 1, 4);          // R4: equal level, lower number wins
    wr(3, 6, 0);
    chk_req(3, 1, 6);          // R3, R11: more urgent triggered source wins
    // R10: clear-pending discards
    wr(2, 6, 0); wr(2, 4, 0); wr(2, 9, 0);
    chk_req(10, 0, 0);
    rd_chk(2, 6, 0, 10);

    // R8: threshold
    wr(0, 10, 8'hA0); wr(1, 10, 1);
    wr(2, 4, 1); wr(2, 10, 1);
    wr(4, 1, 8'h40);
    chk_req(8, 0, 0);
    wr(4, 1, 8'h60);
    chk_req(8, 1, 4);
    wr(4, 1, 8'h20);
    chk_req(8, 0, 0);
    wr(4, 1, 8'h00);
    chk_req(8, 1, 4);
    wr(2, 10, 0);

    // R7: global gate
    wr_chk(4, 2, 1, 0, 7);
    chk_req(7, 0, 0);
    rd_chk(1, 4, 1, 7);
    wr_chk(4, 2, 1, 1, 7);
    wr_chk(4, 2, 0, 1, 7);
    chk_req(7, 1, 4);
    wr(2, 4, 0);
    chk_req(7, 0, 0);

    // R5, R6: nesting and grouping
    wr(0, 12, 8'h60); wr(0, 13, 8'h40); wr(0, 14, 8'h20);
    wr(1, 12, 1); wr(1, 13, 1); wr(1, 14, 1);
    wr(2, 12, 1);
    chk_req(5, 1, 12);
    do_ack(12);
    wr(2, 13, 1);
    chk_req(5, 1, 13);         // R5: level 2 preempts level 3
    do_ack(12);
    wr(4, 0, 1);               // one preemption bit: levels 1..3 share group 0
    wr(2, 14, 1);
    chk_req(6, 0, 0);          // R6: same group, better sub-order, no preemption
    do_ret();
    chk_req(6, 0, 0);
    do_ret();
    chk_req(6, 1, 14);         // R6: taken once the stack is empty
    do_ack(12);
    do_ret();
    wr(4, 0, 5);               // R5: grouping 5 acts like 3
    wr(2, 12, 1);
    chk_req(5, 1, 12);
    do_ack(12);
    wr(2, 13, 1);
    chk_req(5, 1, 13);
    wr(2, 13, 0);
    chk_req(10, 0, 0);
    do_ret();
    chk_req(13, 0, 0);

    // R10: a line held high does not re-pend after a clear
    wr(1, 20, 1);
    set_line(20, 1'b1);
    chk_req(11, 1, 20);
    wr(2, 20, 0);
    chk_req(10, 0, 0);
    rd_chk(2, 20, 0, 10);
    set_line(20, 1'b0);

    repeat (2) @(negedge clk);
    wait (sb_q.size() == 0);
    #1;
    done = 1'b1;
    report();
  end
endmodule